// File: doc/BRIEF.md
# Infoframe Packet Scheduler

This block stores auxiliary video infoframe packets in three typed buffers and sends the enabled ones as a byte stream once per frame. Software programs it through a 32-bit control word and fills the buffers through a single 32-bit data port. The control word holds the global switch, the output port tag, the buffer that data-port writes land in, the repeat rate, and one enable per packet type.

Each buffer holds 36 bytes, loaded as nine little-endian words. The first word carries the three header bytes and an ECC placeholder, which is neither sent nor summed. The next byte is the checksum, followed by the body. On a rising edge of `vsync`, the engine queues the enabled packets allowed by the rate setting. Before sending each packet, it verifies that the byte sum is zero. A packet that fails this check is dropped and raises a sticky error flag.

Top module: `infoframe_sched`

## Requirements
- R1: After reset the control readback is 0, and `pkt_valid`, `pkt_last` and `stat_err` are 0.
- R2: The control word reads back only these fields; all other bits read 0. Bit 31 is the global enable. Bits 30:29 are the port tag, which also drives `pkt_port`. Bits 21, 22 and 24 enable the AVI, vendor and SPD types. Bits 20:19 select the buffer. Bits 17:16 set the rate.
- R3: A packet is sent as a contiguous run of valid bytes: byte 0, byte 1 and byte 2 of the buffer, then buffer bytes 4 through 4+L. L is byte 2 capped at 31. Buffer byte n is byte n%4, little-endian, of word n/4. `pkt_last` is high on the final byte only.
- R4: Buffer-select code 0 targets AVI, code 1 targets vendor and code 3 targets SPD. Data writes under code 2 are dropped. A control write that changes the select resets the word pointer to 0. Each data write advances the pointer, and the pointer wraps after word 8.
- R5: When several types are queued in one frame, they are sent in the order AVI, then vendor, then SPD.
- R6: At rate 0 the queued types are sent once, and their enable bits then read back 0. A later vsync sends nothing.
- R7: At rate 1 every enabled type is sent on every vsync.
- R8: At rate 2 the first vsync after a control write sends and the next one does not, alternating from then on.
- R9: A buffer whose byte sum, excluding byte 3, is not 0 mod 256 is skipped, and `stat_err` is set. The flag stays set until a `stat_rd` pulse clears it.
- R10: Nothing is sent when the global enable is 0 or when the rate is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Control word readback |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | 32 | Data port word |
| stat_rd | input | 1 | Status read pulse; clears the error flag |
| stat_err | output | 1 | Sticky checksum error flag |
| vsync | input | 1 | Vertical sync level; the rising edge schedules a frame |
| pkt_port | output | 2 | Port tag from the control word |
| pkt_valid | output | 1 | Output byte valid |
| pkt_data | output | 8 | Output byte |
| pkt_last | output | 1 | Final byte of a packet |

## Verification
The bench uses the default of nine words per buffer, which gives 36 bytes per buffer. At this size, a sweep of the header length byte from 0 to 33 covers every body length up to the capacity cap of 31 and passes beyond it. At the same depth, a tenth data write lands on word 0, which shows the wraparound directly at the output. Multi-frame sequences cover the three packet order and the rate settings, and deliberately corrupted checksums cover the error flag.

// File: rtl/infoframe_sched.sv
module infoframe_sched #(
  parameter int WORDS = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        data_we,
  input  logic [31:0] data_wdata,
  input  logic        stat_rd,
  output logic        stat_err,
  input  logic        vsync,
  output logic [1:0]  pkt_port,
  output logic        pkt_valid,
  output logic [7:0]  pkt_data,
  output logic        pkt_last
);
  localparam int NBYTES = WORDS * 4;
  localparam int MAXB   = NBYTES - 5;
  localparam int CW     = $clog2(NBYTES + 1);
  localparam int PW     = $clog2(WORDS);

  logic          g_en;
  logic [1:0]    port_q, sel_q, rate_q;
  logic [2:0]    te, pend, mask;
  logic [PW-1:0] wptr;
  logic [31:0]   mem [3][WORDS];
  logic          vs_q, par, sending, err;
  logic [CW-1:0] idx, lastidx, bsel;
  logic [1:0]    cur, wbuf;
  logic [7:0]    sum, hb2;
  logic          vs_rise, start;

  wire unused_ctl_bits = ^{ctl_wdata[28:25], ctl_wdata[23], ctl_wdata[18], ctl_wdata[15:0]};

  assign ctl_rdata = {g_en, port_q, 4'b0, te[2], 1'b0, te[1], te[0], sel_q, 1'b0, rate_q, 16'b0};
  assign pkt_port  = port_q;
  assign stat_err  = err;
  assign wbuf      = (sel_q == 2'd3) ? 2'd2 : sel_q;
  assign vs_rise   = vsync & ~vs_q;
  assign start     = vs_rise & g_en & ~sending & (pend == 3'b0);
  assign cur       = pend[0] ? 2'd0 : (pend[1] ? 2'd1 : 2'd2);
  assign hb2       = mem[cur][0][23:16];
  assign lastidx   = (hb2 > 8'(MAXB)) ? CW'(MAXB + 3) : CW'(hb2) + CW'(3);
  assign bsel      = (idx < CW'(3)) ? idx : idx + CW'(1);
  assign pkt_valid = sending;
  assign pkt_last  = sending && (idx == lastidx);
  assign pkt_data  = sending ? mem[cur][bsel[CW-1:2]][{bsel[1:0], 3'b000} +: 8] : 8'h00;

  always_comb begin
    case (rate_q)
      2'd0, 2'd1: mask = te;
      2'd2:       mask = par ? 3'b0 : te;
      default:    mask = 3'b0;
    endcase
  end

  always_comb begin
    sum = 8'h00;
    for (int w = 0; w < WORDS; w++)
      for (int l = 0; l < 4; l++)
        if (!(w == 0 && l == 3)) sum = sum + mem[cur][w][l*8 +: 8];
  end

  always_ff @(posedge clk)
    if (data_we && sel_q != 2'd2) mem[wbuf][wptr] <= data_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_en <= 1'b0; port_q <= '0; sel_q <= '0; rate_q <= '0; te <= '0;
      wptr <= '0; vs_q <= 1'b0; par <= 1'b0; sending <= 1'b0; err <= 1'b0;
      pend <= '0; idx <= '0;
    end else begin
      vs_q <= vsync;
      if (data_we && sel_q != 2'd2)
        wptr <= (wptr == PW'(WORDS - 1)) ? '0 : wptr + 1'b1;
      if (stat_rd) err <= 1'b0;
      if (start) begin
        pend <= mask;
        if (rate_q == 2'd2) par <= ~par;
        if (rate_q == 2'd0) te <= 3'b0;
      end
      if (!sending) begin
        if (pend != 3'b0) begin
          if (sum == 8'h00) begin
            sending <= 1'b1;
            idx <= '0;
          end else begin
            err <= 1'b1;
            pend[cur] <= 1'b0;
          end
        end
      end else if (pkt_last) begin
        sending <= 1'b0;
        pend[cur] <= 1'b0;
      end else begin
        idx <= idx + CW'(1);
      end
      if (ctl_we) begin
        g_en   <= ctl_wdata[31];
        port_q <= ctl_wdata[30:29];
        te     <= {ctl_wdata[24], ctl_wdata[22], ctl_wdata[21]};
        rate_q <= ctl_wdata[17:16];
        sel_q  <= ctl_wdata[20:19];
        par    <= 1'b0;
        if (ctl_wdata[20:19] != sel_q) wptr <= '0;
      end
    end
  end

  a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_last |-> pkt_valid);
  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_last) |=> pkt_valid);
  a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wptr) < WORDS);
  a_r6_once_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rate_q == 2'd0 && !ctl_we) |=> (te == 3'b0));
  a_r8_skip_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rate_q == 2'd2 && par) |=> (pend == 3'b0));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !stat_rd) |=> err);
endmodule

// File: tb/tb_infoframe_sched.sv
`timescale 1ns/1ps
module tb_infoframe_sched;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, data_we = 0, stat_rd = 0, vsync = 0;
  logic [31:0] ctl_wdata = 0, data_wdata = 0;
  logic [31:0] ctl_rdata;
  logic stat_err, pkt_valid, pkt_last;
  logic [1:0] pkt_port;
  logic [7:0] pkt_data;

  infoframe_sched dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] eb [3][36];
  logic [7:0] xs [256];
  logic       xl [256];
  logic [7:0] cap [256];
  logic       capl [256];
  int nx = 0, ncap = 0;

  always @(negedge clk)
    if (rst_n && pkt_valid && ncap < 256) begin
      cap[ncap] = pkt_data; capl[ncap] = pkt_last; ncap++;
    end

  function automatic logic [31:0] mk(bit en, int port, logic [2:0] t, int sel, int rate);
    return {en, 2'(port), 4'b0, t[2], 1'b0, t[1], t[0], 2'(sel), 1'b0, 2'(rate), 16'b0};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [31:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_data(logic [31:0] v);
    @(negedge clk); data_we = 1; data_wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic load(int code, int bi, int h0, int h1, int len, int seed, bit corrupt);
    logic [7:0] b [36];
    logic [7:0] s;
    int n;
    for (int k = 0; k < 36; k++) b[k] = 8'h00;
    b[0] = 8'(h0); b[1] = 8'(h1); b[2] = 8'(len); b[3] = 8'hA5;
    n = (len > 31) ? 31 : len;
    for (int k = 1; k <= n; k++) b[4+k] = 8'(seed + 7*k);
    s = 8'h00;
    for (int k = 0; k < 36; k++) if (k != 3) s = s + b[k];
    b[4] = 8'h00 - s + (corrupt ? 8'h01 : 8'h00);
    for (int k = 0; k < 36; k++) eb[bi][k] = b[k];
    wr_ctl(mk(0, 1, 3'b000, 2, 0));
    wr_ctl(mk(0, 1, 3'b000, code, 0));
    for (int w = 0; w < 9; w++) wr_data({b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]});
  endtask

  task automatic expect_add(int bi);
    int n;
    n = (eb[bi][2] > 31) ? 31 : int'(eb[bi][2]);
    for (int k = 0; k < 3; k++) begin xs[nx] = eb[bi][k]; xl[nx] = 0; nx++; end
    for (int k = 0; k <= n; k++) begin xs[nx] = eb[bi][4+k]; xl[nx] = (k == n); nx++; end
  endtask

  task automatic frame();
    @(negedge clk); vsync = 1;
    repeat (2) @(negedge clk);
    vsync = 0;
    repeat (130) @(negedge clk);
  endtask

  task automatic cmp(string tag);
    int m, first;
    m = 0; first = -1;
    chk(ncap == nx, {tag, " byte count"}, ncap, nx);
    for (int k = 0; k < nx && k < ncap; k++)
      if (cap[k] !== xs[k] || capl[k] !== xl[k]) begin
        m++;
        if (first < 0) first = k;
      end
    if (first >= 0) chk(0, {tag, " byte value"}, int'(cap[first]), int'(xs[first]));
    else chk(1, tag, 0, 0);
  endtask

  task automatic arm();
    ncap = 0; nx = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_rdata == 0, "R1 ctl readback", int'(ctl_rdata), 0);
    chk(!pkt_valid && !pkt_last, "R1 stream idle", int'(pkt_valid), 0);
    chk(!stat_err, "R1 error flag", int'(stat_err), 0);

    // R2 field readback mask and port tag
    wr_ctl(32'hFFFF_FFFF);
    chk(ctl_rdata == 32'hE17B_0000, "R2 readback mask", int'(ctl_rdata), int'(32'hE17B_0000));
    chk(pkt_port == 2'd3, "R2 port tag", int'(pkt_port), 3);
    wr_ctl(32'h0);

    // R3 length sweep including the capacity cap
    for (int len = 0; len <= 33; len++) begin
      load(0, 0, 8'h82, 2, len, len * 3 + 1, 0);
      arm(); expect_add(0);
      wr_ctl(mk(1, 1, 3'b001, 0, 1));
      frame();
      cmp("R3");
    end

    // R5 fixed ordering of three packets
    load(0, 0, 8'h82, 2, 13, 11, 0);
    load(1, 1, 8'h81, 1, 8, 40, 0);
    load(3, 2, 8'h83, 1, 25, 90, 0);
    wr_ctl(mk(1, 1, 3'b111, 0, 1));
    arm(); expect_add(0); expect_add(1); expect_add(2);
    frame();
    cmp("R5");

    // R7 repeat every vsync
    for (int i = 0; i < 2; i++) begin
      arm(); expect_add(0); expect_add(1); expect_add(2);
      frame();
      cmp("R7");
    end

    // R6 send once then enable clears
    wr_ctl(mk(1, 1, 3'b100, 0, 0));
    arm(); expect_add(2);
    frame();
    cmp("R6");
    chk((ctl_rdata & 32'h0160_0000) == 0, "R6 enable cleared", int'(ctl_rdata), 0);
    arm();
    frame();
    chk(ncap == 0, "R6 no resend", ncap, 0);

    // R8 every second vsync, port tag 2
    wr_ctl(mk(1, 2, 3'b010, 0, 2));
    chk(pkt_port == 2'd2, "R2 port tag", int'(pkt_port), 2);
    for (int i = 0; i < 4; i++) begin
      arm();
      if (i % 2 == 0) expect_add(1);
      frame();
      cmp("R8");
    end

    // R9 corrupted checksum skipped, sticky flag
    load(0, 0, 8'h82, 2, 13, 5, 1);
    wr_ctl(mk(1, 1, 3'b011, 0, 1));
    arm(); expect_add(1);
    frame();
    cmp("R9");
    chk(stat_err == 1, "R9 flag set", int'(stat_err), 1);
    repeat (5) @(negedge clk);
    chk(stat_err == 1, "R9 flag sticky", int'(stat_err), 1);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk(stat_err == 0, "R9 flag cleared", int'(stat_err), 0);

    // R4 pointer reset on select change, wrap, dropped code 2
    wr_ctl(mk(0, 1, 3'b000, 1, 0));
    wr_data(32'hDEAD_BEEF); wr_data(32'hDEAD_BEEF);
    load(1, 1, 8'h81, 1, 6, 77, 0);
    load(0, 0, 8'h82, 2, 13, 21, 0);
    eb[0][0] = eb[0][0] + 8'h01; eb[0][1] = eb[0][1] - 8'h01; eb[0][3] = 8'h5A;
    wr_data({eb[0][3], eb[0][2], eb[0][1], eb[0][0]});
    wr_ctl(mk(0, 1, 3'b000, 2, 0));
    for (int w = 0; w < 9; w++) wr_data(32'hFFFF_FFFF);
    wr_ctl(mk(1, 1, 3'b011, 2, 1));
    arm(); expect_add(0); expect_add(1);
    frame();
    cmp("R4");

    // R10 global disable and reserved rate
    wr_ctl(mk(0, 1, 3'b111, 0, 1));
    arm(); frame();
    chk(ncap == 0, "R10 disabled", ncap, 0);
    wr_ctl(mk(1, 1, 3'b111, 0, 3));
    arm(); frame();
    chk(ncap == 0, "R10 rate 3", ncap, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule